// File: doc/BRIEF.md
# Pipelined Burst SRAM Command Controller

This block is a synchronous single-port memory that sits behind a pipelined command interface with no turnaround cycles. At every rising clock edge with the clock enable asserted, it decodes chip select, load/advance, read/write and the byte-write strobes into one operation. The operation is a deselect, the start or continuation of a read burst, the start or continuation of a write burst, a no-op read or aborted write, or, when the clock enable is withheld, a stall. A 2-bit linear counter generates the burst addresses. Data moves through an internal register-array memory.

Read data goes onto the data bus in the cycle after the first enabled edge that follows its command, so the host samples it at the second enabled edge. Write data and byte strobes are taken at the second enabled edge after their command. Read and write commands can therefore alternate back to back with no idle cycles. The bus is split into an input word, an output word and a drive enable, and a pad ring outside this block builds the tri-state driver from them.

Top module: `burst_sram_ctrl`

## Requirements
- R1: From reset until the first read result is presented, `dq_oe` is 0.
- R2: For a read command taken at enabled edge E0, `dq_out` holds the word at its address, with `dq_oe` high, after enabled edge E1 and until the next enabled edge. Write data `dq_in` and strobes `bw_n` for a write command at E0 are taken at enabled edge E2.
- R3: Data lane i is bits 8i+7..8i. A low `bw_n[i]` in the write data slot updates lane i only, and a high `bw_n[i]` leaves that lane unchanged.
- R4: A write whose data slot has all `bw_n` bits high (aborted write) leaves memory unchanged.
- R5: A load cycle (`adv_ld_n`=0, `cs_n`=0) starts a burst at `addr`. Each advance cycle (`adv_ld_n`=1) during a burst moves to {upper bits unchanged, low two bits + 1 mod 4}, so the fifth address of the burst equals the first.
- R6: The burst direction is taken from `we_n` in the load cycle (0 = write, 1 = read). Advance cycles ignore `we_n` and `cs_n`.
- R7: A load cycle with `cs_n`=1 is a deselect and ends any burst. An advance cycle while no burst is active (after a deselect, a sleep cycle or reset) performs nothing.
- R8: While `cke_n`=1, the edge is ignored: no write happens, no command is taken, and the pipeline holds. A bus driven with read data stays driven with the same word, and a bus released during a write slot stays released.
- R9: `dq_oe` is high only in a read data slot with `oe_n`=0. A read slot with `oe_n`=1 is a dummy read with the bus released. A write slot never drives the bus, whatever the level of `oe_n`.
- R10: While `sleep`=1, no command is taken, no write is committed, no read result is loaded, any burst ends, and `dq_oe` is 0.
- R11: A read of the address written by the immediately preceding command returns the newly written lanes, with no idle cycle between the two commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high stalls the edge |
| cs_n | input | 1 | Active-low chip select, used in load cycles |
| adv_ld_n | input | 1 | 0 = load new address, 1 = advance burst |
| we_n | input | 1 | 0 = write burst, 1 = read burst (load cycles only) |
| bw_n | input | DW/8 | Active-low byte-write strobes, taken in the write data slot |
| oe_n | input | 1 | Active-low output enable |
| sleep | input | 1 | Blocks all operations and releases the bus |
| addr | input | AW | Word address for load cycles |
| dq_in | input | DW | Write data from the bus |
| dq_out | output | DW | Read data to the bus driver |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The in-line assertions check, on every cycle, the properties of a single edge: a stall freezes the output and pipeline registers, the burst counter steps by one modulo four with its upper bits fixed, an advance with no active burst issues nothing, advance cycles keep the locked direction, a write slot leaves the bus released, and sleep forces it off. Only the bench's scenarios can show that data comes back intact after it travels through the pipeline. These scenarios cover lane-masked writes, aborted writes, wrapped burst readback, a stall in the middle of a burst, sleep during a write slot, and a read that follows a write to the same address. A behavioural model predicts the bus on every clock, and targeted checks compare the returned words against constants.

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke_n,
  input  logic            cs_n,
  input  logic            adv_ld_n,
  input  logic            we_n,
  input  logic [DW/8-1:0] bw_n,
  input  logic            oe_n,
  input  logic            sleep,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   dq_in,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe
);
  localparam int LANES = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          active, lock_wr;
  logic [AW-1:0] cur;
  logic          s1_v, s1_wr, s2_v, s2_wr;
  logic [AW-1:0] s1_a, s2_a;
  logic          rd_q;
  logic [DW-1:0] rdata_q;

  wire go = ~cke_n;
  wire [AW-1:0] nxt = {cur[AW-1:2], cur[1:0] + 2'd1};

  logic          c_v, c_wr, c_act;
  logic [AW-1:0] c_a;

  always_comb begin
    c_v   = 1'b0;
    c_wr  = lock_wr;
    c_a   = cur;
    c_act = 1'b0;
    if (!sleep) begin
      if (!adv_ld_n) begin
        if (!cs_n) begin
          c_v   = 1'b1;
          c_wr  = ~we_n;
          c_a   = addr;
          c_act = 1'b1;
        end
      end else if (active) begin
        c_v   = 1'b1;
        c_a   = nxt;
        c_act = 1'b1;
      end
    end
  end

  wire commit  = go & s2_v & s2_wr & ~sleep;
  wire rd_load = s1_v & ~s1_wr & ~sleep;

  logic [DW-1:0] fwd;
  always_comb begin
    fwd = mem[s1_a];
    if (commit && (s2_a == s1_a))
      for (int i = 0; i < LANES; i++)
        if (!bw_n[i]) fwd[8*i +: 8] = dq_in[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      lock_wr <= 1'b0;
      cur     <= '0;
      s1_v    <= 1'b0;
      s1_wr   <= 1'b0;
      s1_a    <= '0;
      s2_v    <= 1'b0;
      s2_wr   <= 1'b0;
      s2_a    <= '0;
      rd_q    <= 1'b0;
      rdata_q <= '0;
    end else if (go) begin
      active  <= c_act;
      lock_wr <= c_wr;
      cur     <= c_a;
      s1_v    <= c_v;
      s1_wr   <= c_wr;
      s1_a    <= c_a;
      s2_v    <= s1_v;
      s2_wr   <= s1_wr;
      s2_a    <= s1_a;
      rd_q    <= rd_load;
      if (rd_load) rdata_q <= fwd;
    end
  end

  always_ff @(posedge clk) begin
    if (commit)
      for (int i = 0; i < LANES; i++)
        if (!bw_n[i]) mem[s2_a][8*i +: 8] <= dq_in[8*i +: 8];
  end

  assign dq_out = rdata_q;
  assign dq_oe  = rd_q & ~oe_n & ~sleep;

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(rd_q) && $stable(rdata_q) && $stable(s1_a) && $stable(cur));

  p_burst_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && adv_ld_n && active && !sleep) |=>
      (cur[1:0] == $past(cur[1:0]) + 2'd1) && (cur[AW-1:2] == $past(cur[AW-1:2])));

  p_lock_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && adv_ld_n && active && !sleep) |=> (s1_wr == $past(lock_wr)) && s1_v);

  p_cont_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && adv_ld_n && !active) |=> !s1_v);

  p_write_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && s1_v && s1_wr) |=> !dq_oe);

  p_sleep_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);
endmodule

// File: tb/burst_sram_ctrl_test.sv
module burst_sram_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke_n = 1'b0, cs_n = 1'b1, adv_ld_n = 1'b0, we_n = 1'b1;
  logic [3:0]  bw_n = 4'hF;
  logic        oe_n = 1'b0, sleep = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] dq_in = '0;
  logic [31:0] dq_out;
  logic        dq_oe;

  always #10 clk = ~clk;

  burst_sram_ctrl #(.DW(32), .AW(6)) uut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_n(cs_n), .adv_ld_n(adv_ld_n),
    .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference: pending command queue, -1 = nothing, else wr*65536 + address
  logic [31:0] mm [64];
  int          pq[$];
  bit          m_act, m_wr, m_rd;
  int          m_cur;
  logic [31:0] m_dat;

  initial begin
    for (int i = 0; i < 64; i++) mm[i] = '0;
    pq = '{-1, -1};
    m_act = 0; m_wr = 0; m_rd = 0; m_cur = 0; m_dat = '0;
  end

  always @(posedge clk) begin
    int o, n, c;
    if (!rst_n) begin
      pq = '{-1, -1};
      m_act = 0; m_rd = 0; m_cur = 0;
    end else if (!cke_n) begin
      o = pq[0];
      n = pq[1];
      if (o >= 0 && o >= 65536 && !sleep)
        for (int i = 0; i < 4; i++)
          if (!bw_n[i]) mm[o % 65536][8*i +: 8] = dq_in[8*i +: 8];
      m_rd = (n >= 0) && (n < 65536) && !sleep;
      if (m_rd) m_dat = mm[n];
      c = -1;
      if (sleep) m_act = 0;
      else if (!adv_ld_n) begin
        if (cs_n) m_act = 0;
        else begin
          m_act = 1; m_wr = !we_n; m_cur = int'(addr);
          c = (m_wr ? 65536 : 0) + m_cur;
        end
      end else if (m_act) begin
        m_cur = (m_cur / 4) * 4 + ((m_cur + 1) % 4);
        c = (m_wr ? 65536 : 0) + m_cur;
      end
      void'(pq.pop_front());
      pq.push_back(c);
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic cmp;
    logic eoe;
    eoe = m_rd & ~oe_n & ~sleep;
    check({tag, " bus enable vs model"}, {31'd0, dq_oe}, {31'd0, eoe});
    if (eoe) check({tag, " bus data vs model"}, dq_out, m_dat);
  endtask

  task automatic cyc(input logic ck, input logic cs, input logic adv, input logic we,
                     input logic [3:0] bw, input logic oe, input logic zz,
                     input logic [5:0] a, input logic [31:0] d);
    cke_n = ck; cs_n = cs; adv_ld_n = adv; we_n = we; bw_n = bw;
    oe_n = oe; sleep = zz; addr = a; dq_in = d;
    @(posedge clk); #2;
    cmp();
  endtask

  task automatic ld(input logic we, input logic [5:0] a);
    cyc(1'b0, 1'b0, 1'b0, we, 4'hF, 1'b0, 1'b0, a, 32'h0);
  endtask
  task automatic adv(input logic [31:0] d, input logic [3:0] bw);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, bw, 1'b0, 1'b0, 6'd0, d);
  endtask
  task automatic des(input logic [31:0] d, input logic [3:0] bw);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, bw, 1'b0, 1'b0, 6'd0, d);
  endtask
  task automatic bus_is(input string t, input logic [31:0] exp);
    check({t, " driven"}, {31'd0, dq_oe}, 32'd1);
    check({t, " data"}, dq_out, exp);
  endtask
  task automatic bus_off(input string t);
    check({t, " released"}, {31'd0, dq_oe}, 32'd0);
  endtask

  localparam logic [31:0] D0 = 32'h1122_3344, D1 = 32'h5566_7788;
  localparam logic [31:0] D2 = 32'h99AA_BBCC, D3 = 32'hDDEE_F011;
  localparam logic [31:0] W8 = {D0[31:8], 8'hFF};
  localparam logic [31:0] W9 = D1 & 32'hFF00_FFFF;
  localparam logic [31:0] V12 = 32'hC0FF_EE12, V13 = 32'hA5A5_5A13;

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (3) @(posedge clk);
    #2;
    bus_off("R1 in reset");
    rst_n = 1'b1;
    des(0, 4'hF);
    bus_off("R1 after reset");

    tag = "R2";
    ld(1'b0, 6'd8); adv(0, 4'hF); adv(D0, 4'h0); adv(D1, 4'h0);
    des(D2, 4'h0); des(D3, 4'h0);
    ld(1'b1, 6'd8);
    adv(0, 4'hF); bus_is("R2 beat0", D0);
    adv(0, 4'hF); bus_is("R2 beat1", D1);
    adv(0, 4'hF); bus_is("R2 beat2", D2);
    tag = "R5";
    adv(0, 4'hF); bus_is("R5 beat3", D3);
    des(0, 4'hF); bus_is("R5 wrapped to start", D0);
    ld(1'b1, 6'd10);
    adv(0, 4'hF); bus_is("R5 off2", D2);
    adv(0, 4'hF); bus_is("R5 off3", D3);
    adv(0, 4'hF); bus_is("R5 off0", D0);
    adv(0, 4'hF); bus_is("R5 off1", D1);
    des(0, 4'hF); bus_is("R5 wrap off2", D2);

    tag = "R3";
    ld(1'b0, 6'd8); des(0, 4'hF); des(32'hFFFF_FFFF, 4'b1110);
    ld(1'b0, 6'd9); des(0, 4'hF); des(32'h0, 4'b1011);
    ld(1'b1, 6'd8); ld(1'b1, 6'd9);
    bus_is("R3 lane0 only", W8);
    des(0, 4'hF); bus_is("R3 lane2 only", W9);

    tag = "R4";
    ld(1'b0, 6'd10); des(0, 4'hF); des(32'h0, 4'hF);
    ld(1'b1, 6'd10); des(0, 4'hF); bus_is("R4 aborted write", D2);

    tag = "R6";
    ld(1'b1, 6'd8);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 6'd0, 32'h0);
    bus_is("R6 stays read", W8);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 6'd0, 32'h0);
    bus_is("R6 advance ignores we_n", W9);
    des(0, 4'h0); bus_is("R6 third beat", D2);
    ld(1'b1, 6'd9); des(0, 4'hF); bus_is("R6 memory intact", W9);

    tag = "R7";
    des(0, 4'hF);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 6'd8, 32'h0);
    bus_off("R7 after deselect");
    des(0, 4'hF); bus_off("R7 continue-deselect idle");

    tag = "R8";
    ld(1'b1, 6'd8);
    adv(0, 4'hF); bus_is("R8 before stall", W8);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 6'd0, 32'h0);
    bus_is("R8 read stall holds", W8);
    adv(0, 4'hF); bus_is("R8 resumes", W9);
    des(0, 4'hF); bus_is("R8 next beat", D2);
    ld(1'b0, 6'd12); des(0, 4'hF);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 6'd0, 32'hDEAD_BEEF);
    bus_off("R8 write stall released");
    des(V12, 4'h0);
    ld(1'b1, 6'd12); des(0, 4'hF); bus_is("R8 stalled write data", V12);

    tag = "R9";
    ld(1'b1, 6'd8);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 1'b1, 1'b0, 6'd0, 32'h0);
    bus_off("R9 dummy read");
    des(0, 4'hF); bus_is("R9 read with oe", W9);
    ld(1'b0, 6'd14); des(0, 4'hF); bus_off("R9 write slot with oe low");
    des(32'h1414_1414, 4'h0);

    tag = "R10";
    ld(1'b0, 6'd12); des(0, 4'hF);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 6'd0, 32'hBAD0_BAD0);
    bus_off("R10 sleep");
    des(0, 4'hF);
    ld(1'b1, 6'd12); des(0, 4'hF); bus_is("R10 write blocked", V12);
    ld(1'b1, 6'd8);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 6'd0, 32'h0);
    bus_off("R10 read blocked");
    adv(0, 4'hF); bus_off("R10 burst ended");

    tag = "R11";
    ld(1'b0, 6'd13); ld(1'b1, 6'd13);
    des(V13, 4'h0); bus_is("R11 write then read", V13);
    des(0, 4'hF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule